// File: doc/BRIEF.md
# Byte Serial Port Controller with Status Flags

This block is a register-mapped controller for an 8-bit synchronous serial link. A CPU bus writes a transmit byte, reads back the received byte, and reads a status register that holds two sticky flags: a collision flag and a completion flag. Each flag can raise an interrupt through its own enable bit. The bus supports single-cycle byte reads, byte writes and single-bit writes.

A transmit write puts the byte straight into the shift engine. In master mode the write also starts a transfer clocked by an internal divider. In slave mode the engine waits for edges on an external clock input. Data moves most significant bit first. The input is sampled on the rising serial clock edge and the output shifts on the falling edge.

Each flag has two ways to be cleared. Software can write a zero to it, or it can read the status register and then make the matching access to a data register. A write that collides with a transfer is kept in the transmit holding register, so software can read it back.

Top module: `ssp_ctrl`

## Requirements
- R1: Register addresses are 0 for transmit, 1 for receive, 2 for status, 3 for interrupt enable and 4 for control (bit 0 = master mode). In the status register, bit 1 is the collision flag and bit 0 is the completion flag, and bits 7..2 always read 0. After reset every register reads 0, `irq` is low and `sck_o` is low.
- R2: In master mode a transmit write starts a transfer. `sck_o` idles low and each half period lasts DIV clock cycles. Over 8 clock pulses the transmit byte leaves on `sdo` MSB first, and `sdi` is sampled on each rising edge. The received byte is then read at address 1.
- R3: In slave mode a transmit write only loads the shift register: `sck_o` stays low and nothing completes. The transfer is then clocked by 8 pulses on `sck_i`, with the same bit order and edges as in R2.
- R4: A transmit write while a transfer is in progress sets the collision flag in the next cycle. The transfer still carries the original byte, and a read of address 0 returns the colliding value.
- R5: The collision flag clears when software writes 0 to status bit 1, either by a byte write or by a bit write. It also clears when a status read is followed directly by a transmit write. Writing 1 to the flag has no effect.
- R6: The completion flag sets on the clock edge that produces the 8th rising serial clock edge of a transfer.
- R7: Writing 0 to status bit 0 clears the completion flag only if the receive register has been read since the flag was last set. Before that read, such a write has no effect. Writing 1 never has an effect.
- R8: A status read followed directly by a receive read clears the completion flag. A receive read with no status read just before it clears nothing. An access to any other register in between cancels the sequence.
- R9: `irq` is high exactly when a flag is set and its enable bit is 1. Enable bit 1 belongs to the collision flag and enable bit 0 to the completion flag.
- R10: A completed transfer overwrites the receive register even if it has not been read, and no flag other than completion is raised.
- R11: When a flag's set event and one of its clear conditions fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Byte read strobe, one cycle |
| bus_wr | input | 1 | Byte write strobe, one cycle |
| bus_bwr | input | 1 | Single-bit write strobe, value taken from bus_wdata[0] |
| bus_addr | input | 3 | Register address |
| bus_bit | input | 3 | Bit position for a bit write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The master path is driven with complementary and alternating byte pairs (00/FF, A5/5A) and with single-bit bytes (80/01). These show whether the bit order is right and whether the transmit and receive directions are swapped or stuck. The slave path is clocked one bit at a time by the bench, so bus accesses can be placed between serial edges. This allows collisions before and after a status read, and a set event that coincides with a clear condition. The clear sequences are run with and without an intervening access and with the receive read placed before or after the zero write. This separates the armed-sequence path from the gated zero-write path.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_TXD  = 3'd0;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;

  localparam int BIT_COLL = 1;
  localparam int BIT_CMPL = 0;

  // status byte image: reserved bits forced to zero
  function automatic logic [7:0] stat_word(input logic coll, input logic cmpl);
    return {6'b0, coll, cmpl};
  endfunction

  // interrupt request from flags and enables
  function automatic logic irq_of(input logic coll, input logic cmpl, input logic [1:0] en);
    return (coll & en[BIT_COLL]) | (cmpl & en[BIT_CMPL]);
  endfunction

  // last count value of a divider of length div
  function automatic int div_last(input int div);
    return (div > 1) ? div - 1 : 0;
  endfunction
endpackage

// File: rtl/ssp_clkdiv.sv
module ssp_clkdiv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(ssp_pkg::div_last(DIV));

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else cnt <= cnt + CW'(1);
  end

  a_r2_div_bound: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LAST);
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift #(
  parameter int W   = 8,
  parameter int DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mst,
  input  logic         load,
  input  logic [W-1:0] ld_data,
  input  logic         sck_i,
  input  logic         sdi,
  output logic         sck_o,
  output logic         sdo,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_word
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sh;
  logic          samp;
  logic          busy_q;
  logic [CW-1:0] bitcnt;
  logic          sck_q;
  logic          s1, s2, s3;
  logic          tick;
  logic          rise_raw, fall_raw, rise_ok, fall_ok;

  ssp_clkdiv #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (mst && busy_q),
    .tick (tick)
  );

  // external clock synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {s1, s2, s3} <= 3'b000;
    else {s1, s2, s3} <= {sck_i, s1, s2};
  end

  assign rise_raw = mst ? (tick && !sck_q) : (s2 && !s3);
  assign fall_raw = mst ? (tick && sck_q)  : (!s2 && s3);
  assign rise_ok  = rise_raw && (bitcnt != FULL);
  assign fall_ok  = fall_raw && busy_q;
  assign done     = rise_ok && (bitcnt == LAST);
  assign rx_word  = {sh[W-2:0], sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      samp   <= 1'b0;
      busy_q <= 1'b0;
      bitcnt <= '0;
      sck_q  <= 1'b0;
    end else begin
      if (load) begin
        sh <= ld_data;
        if (mst) begin
          busy_q <= 1'b1;
          bitcnt <= '0;
        end
      end
      if (fall_ok) begin
        sh <= {sh[W-2:0], samp};
        if (bitcnt == FULL) begin
          busy_q <= 1'b0;
          bitcnt <= '0;
        end
      end
      if (rise_ok) begin
        samp   <= sdi;
        busy_q <= 1'b1;
        bitcnt <= bitcnt + CW'(1);
      end
      if (!mst || load) sck_q <= 1'b0;
      else if (tick) sck_q <= ~sck_q;
    end
  end

  assign sck_o = sck_q;
  assign sdo   = sh[W-1];
  assign busy  = busy_q;

  a_r2_idle_low:    assert property (@(posedge clk) disable iff (!rst_n) !busy_q |-> !sck_q);
  a_r3_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n) !mst |=> !sck_q);
  a_r2_cnt_bound:   assert property (@(posedge clk) disable iff (!rst_n) bitcnt <= FULL);
  a_r2_end_full:    assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_q) |-> $past(bitcnt) == FULL);
endmodule

// File: rtl/ssp_flags.sv
module ssp_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_coll,
  input  logic set_cmpl,
  input  logic stat_rd,
  input  logic oth_acc,
  input  logic tx_wr,
  input  logic rx_rd,
  input  logic wr0_coll,
  input  logic wr0_cmpl,
  output logic coll_f,
  output logic cmpl_f
);
  logic armed;
  logic rx_seen;
  logic clr_coll, clr_cmpl;

  assign clr_coll = wr0_coll || (armed && tx_wr);
  assign clr_cmpl = (wr0_cmpl && rx_seen) || (armed && rx_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      rx_seen <= 1'b0;
      coll_f  <= 1'b0;
      cmpl_f  <= 1'b0;
    end else begin
      if (stat_rd) armed <= 1'b1;
      else if (oth_acc) armed <= 1'b0;

      if (set_cmpl) rx_seen <= 1'b0;
      else if (rx_rd) rx_seen <= 1'b1;

      if (set_coll) coll_f <= 1'b1;
      else if (clr_coll) coll_f <= 1'b0;

      if (set_cmpl) cmpl_f <= 1'b1;
      else if (clr_cmpl) cmpl_f <= 1'b0;
    end
  end

  a_r4_coll_sets:  assert property (@(posedge clk) disable iff (!rst_n) set_coll |=> coll_f);
  a_r6_cmpl_sets:  assert property (@(posedge clk) disable iff (!rst_n) set_cmpl |=> cmpl_f);
  a_r11_set_wins:  assert property (@(posedge clk) disable iff (!rst_n) (set_coll && armed && tx_wr) |=> coll_f);
  a_r7_gated_wr0:  assert property (@(posedge clk) disable iff (!rst_n)
                     (wr0_cmpl && !rx_seen && !rx_rd && !set_cmpl) |=> cmpl_f == $past(cmpl_f));
  a_r8_plain_read: assert property (@(posedge clk) disable iff (!rst_n)
                     (rx_rd && !armed && !set_cmpl) |=> cmpl_f == $past(cmpl_f));
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl #(
  parameter int W   = 8,
  parameter int DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_rd,
  input  logic         bus_wr,
  input  logic         bus_bwr,
  input  logic [2:0]   bus_addr,
  input  logic [2:0]   bus_bit,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         irq,
  output logic         sck_o,
  input  logic         sck_i,
  output logic         sdo,
  input  logic         sdi
);
  import ssp_pkg::*;

  logic [W-1:0] txreg, rxreg, rx_word;
  logic [1:0]   ien;
  logic         mst;
  logic         busy, done;
  logic         coll_f, cmpl_f;

  logic sel_tx, sel_rx, sel_st, sel_ie, sel_ct;
  logic tx_wr, rx_rd, stat_rd, oth_acc;
  logic wr0_coll, wr0_cmpl, load, set_coll;

  assign sel_tx = bus_addr == A_TXD;
  assign sel_rx = bus_addr == A_RXD;
  assign sel_st = bus_addr == A_STAT;
  assign sel_ie = bus_addr == A_IEN;
  assign sel_ct = bus_addr == A_CTRL;

  assign tx_wr    = bus_wr && sel_tx;
  assign rx_rd    = bus_rd && sel_rx;
  assign stat_rd  = bus_rd && sel_st;
  assign oth_acc  = (bus_rd || bus_wr || bus_bwr) && !stat_rd;
  assign wr0_coll = sel_st && ((bus_wr && !bus_wdata[BIT_COLL]) ||
                               (bus_bwr && bus_bit == 3'(BIT_COLL) && !bus_wdata[0]));
  assign wr0_cmpl = sel_st && ((bus_wr && !bus_wdata[BIT_CMPL]) ||
                               (bus_bwr && bus_bit == 3'(BIT_CMPL) && !bus_wdata[0]));
  assign load     = tx_wr && !busy;
  assign set_coll = tx_wr && busy;

  ssp_shift #(.W(W), .DIV(DIV)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .mst    (mst),
    .load   (load),
    .ld_data(bus_wdata),
    .sck_i  (sck_i),
    .sdi    (sdi),
    .sck_o  (sck_o),
    .sdo    (sdo),
    .busy   (busy),
    .done   (done),
    .rx_word(rx_word)
  );

  ssp_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_coll(set_coll),
    .set_cmpl(done),
    .stat_rd (stat_rd),
    .oth_acc (oth_acc),
    .tx_wr   (tx_wr),
    .rx_rd   (rx_rd),
    .wr0_coll(wr0_coll),
    .wr0_cmpl(wr0_cmpl),
    .coll_f  (coll_f),
    .cmpl_f  (cmpl_f)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txreg <= '0;
      rxreg <= '0;
      ien   <= 2'b00;
      mst   <= 1'b0;
    end else begin
      if (tx_wr) txreg <= bus_wdata;
      if (done) rxreg <= rx_word;
      if (bus_wr && sel_ie) ien <= bus_wdata[1:0];
      else if (bus_bwr && sel_ie && bus_bit < 3'd2) ien[bus_bit[0]] <= bus_wdata[0];
      if (bus_wr && sel_ct) mst <= bus_wdata[0];
      else if (bus_bwr && sel_ct && bus_bit == 3'd0) mst <= bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (1'b1)
      sel_tx:  bus_rdata = txreg;
      sel_rx:  bus_rdata = rxreg;
      sel_st:  bus_rdata = W'(stat_word(coll_f, cmpl_f));
      sel_ie:  bus_rdata = W'(ien);
      sel_ct:  bus_rdata = W'(mst);
      default: bus_rdata = '0;
    endcase
  end

  assign irq = irq_of(coll_f, cmpl_f, ien);

  a_r10_rx_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
                           !done |=> rxreg == $past(rxreg));
  a_r4_tx_keeps_write:   assert property (@(posedge clk) disable iff (!rst_n)
                           tx_wr |=> txreg == $past(bus_wdata));
endmodule

// File: tb/sim_ssp_ctrl.sv
`timescale 1ns/1ps
module sim_ssp_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0, bus_bwr = 1'b0;
  logic [2:0] bus_addr = '0, bus_bit = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, sck_o, sdo;
  logic       sck_i = 1'b0;
  logic       sdi = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [7:0] cap;
  logic [7:0] d;

  localparam logic [2:0] TXD = 3'd0, RXD = 3'd1, STAT = 3'd2, IEN = 3'd3, CTRL = 3'd4;

  always #2.5 clk = ~clk;

  ssp_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_bwr(bus_bwr),
    .bus_addr(bus_addr), .bus_bit(bus_bit), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sck_o(sck_o), .sck_i(sck_i), .sdo(sdo), .sdi(sdi)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bbit(input logic [2:0] a, input logic [2:0] b, input logic v);
    @(negedge clk);
    bus_addr = a; bus_bit = b; bus_wdata = {7'b0, v}; bus_bwr = 1'b1;
    @(negedge clk);
    bus_bwr = 1'b0;
  endtask

  task automatic brd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // master transfer: bench acts as the far end, returning rx
  task automatic xfer_m(input logic [7:0] tx, input logic [7:0] rx, input bit chk_t);
    logic [7:0] pat;
    int rises, falls, n;
    logic prev;
    bit tseen;
    pat = rx; sdi = rx[7]; cap = '0;
    rises = 0; falls = 0; n = 0; tseen = 0;
    bwr(TXD, tx);
    prev = sck_o;
    while (falls < 8 && n < 2000) begin
      @(negedge clk);
      n++;
      if (sck_o && !prev) begin cap = {cap[6:0], sdo}; rises++; end
      if (!sck_o && prev) begin falls++; pat = pat << 1; sdi = pat[7]; end
      prev = sck_o;
      if (chk_t && irq && !tseen) begin
        tseen = 1;
        chk(rises == 8 && sck_o, "R6 completion on 8th rising edge", rises, 8);
      end
    end
    chk(falls == 8, "R2 eight clock pulses", falls, 8);
    repeat (2) @(negedge clk);
  endtask

  // one slave bit clocked by the bench
  task automatic sbit(input logic b);
    sdi = b;
    repeat (8) @(negedge clk);
    cap = {cap[6:0], sdo};
    sck_i = 1'b1;
    repeat (8) @(negedge clk);
    sck_i = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    logic [7:0] txp [8];
    logic [7:0] rxp [8];
    txp = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80, 8'h01, 8'hC6, 8'h3B};
    rxp = '{8'hFF, 8'h00, 8'h5A, 8'hA5, 8'h01, 8'h80, 8'h39, 8'hD4};
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    brd(STAT, d); chk(d == 8'h00, "R1 status reset", d, 0);
    brd(TXD, d);  chk(d == 8'h00, "R1 tx reset", d, 0);
    brd(RXD, d);  chk(d == 8'h00, "R1 rx reset", d, 0);
    brd(IEN, d);  chk(d == 8'h00, "R1 enable reset", d, 0);
    brd(CTRL, d); chk(d == 8'h00, "R1 control reset", d, 0);
    chk(irq == 1'b0, "R1 irq reset", irq, 0);
    chk(sck_o == 1'b0, "R1 clock idle", sck_o, 0);

    // R2 / R6 / R8 master sweep
    bwr(CTRL, 8'h01); bwr(IEN, 8'h01);
    for (int i = 0; i < 8; i++) begin
      xfer_m(txp[i], rxp[i], i == 0);
      chk(cap == txp[i], "R2 master sdo bits", cap, txp[i]);
      chk(irq == 1'b1, "R6 completion flag irq", irq, 1);
      brd(STAT, d); chk(d == 8'h01, "R1 status layout", d, 1);
      brd(RXD, d);  chk(d == rxp[i], "R2 master received byte", d, rxp[i]);
      chk(irq == 1'b0, "R8 armed receive read clears", irq, 0);
      chk(sck_o == 1'b0, "R2 clock back idle", sck_o, 0);
    end

    // R10 overrun, R7 gated zero write, R8 plain read
    xfer_m(8'h11, 8'h22, 0);
    xfer_m(8'h33, 8'h44, 0);
    brd(RXD, d); chk(d == 8'h44, "R10 rx overwritten", d, 8'h44);
    chk(irq == 1'b1, "R8 plain read leaves flag", irq, 1);
    brd(STAT, d); chk(d == 8'h01, "R10 no extra flag", d, 1);
    bbit(STAT, 3'd0, 1'b0);
    chk(irq == 1'b0, "R7 zero write after read clears", irq, 0);
    xfer_m(8'h55, 8'h66, 0);
    bbit(STAT, 3'd0, 1'b0);
    chk(irq == 1'b1, "R7 zero bit write before read ignored", irq, 1);
    bwr(STAT, 8'h00);
    chk(irq == 1'b1, "R7 zero byte write before read ignored", irq, 1);
    brd(RXD, d); chk(irq == 1'b1, "R8 plain read no clear", irq, 1);
    bwr(STAT, 8'hFF);
    chk(irq == 1'b1, "R7 writing one no effect", irq, 1);
    bwr(STAT, 8'h02);
    chk(irq == 1'b0, "R7 zero byte write after read clears", irq, 0);

    // R8 cancelled sequence
    xfer_m(8'h77, 8'h88, 0);
    brd(STAT, d); bwr(IEN, 8'h01); brd(RXD, d);
    chk(irq == 1'b1, "R8 intervening access cancels", irq, 1);
    brd(STAT, d); brd(RXD, d);
    chk(irq == 1'b0, "R8 sequence clears", irq, 0);

    // R9 enable masking
    xfer_m(8'h0F, 8'hF0, 0);
    bwr(IEN, 8'h00); chk(irq == 1'b0, "R9 masked", irq, 0);
    bwr(IEN, 8'h02); chk(irq == 1'b0, "R9 other enable only", irq, 0);
    bwr(IEN, 8'h01); chk(irq == 1'b1, "R9 enabled", irq, 1);
    brd(STAT, d); brd(RXD, d);

    // R3 slave mode
    bwr(IEN, 8'h03); bwr(CTRL, 8'h00);
    bwr(TXD, 8'hB4);
    repeat (20) @(negedge clk);
    chk(sck_o == 1'b0, "R3 no clock in slave", sck_o, 0);
    chk(irq == 1'b0, "R3 no completion without clock", irq, 0);
    cap = '0;
    for (int k = 7; k >= 0; k--) sbit(8'h6E >> k);
    chk(cap == 8'hB4, "R3 slave sdo bits", cap, 8'hB4);
    brd(STAT, d); chk(d == 8'h01, "R3 slave completion", d, 1);
    brd(RXD, d);  chk(d == 8'h6E, "R3 slave received byte", d, 8'h6E);

    // R4 collision and R5 clears
    bwr(TXD, 8'h3C); cap = '0;
    for (int k = 7; k >= 5; k--) sbit(8'hC3 >> k);
    bwr(TXD, 8'h99);
    chk(irq == 1'b1, "R4 collision irq", irq, 1);
    brd(STAT, d); chk(d == 8'h02, "R4 collision flag", d, 2);
    brd(TXD, d);  chk(d == 8'h99, "R4 colliding value kept", d, 8'h99);
    for (int k = 4; k >= 0; k--) sbit(8'hC3 >> k);
    chk(cap == 8'h3C, "R4 transfer unaffected", cap, 8'h3C);
    brd(RXD, d); chk(d == 8'hC3, "R4 received byte", d, 8'hC3);
    bbit(STAT, 3'd1, 1'b1);
    brd(STAT, d); chk(d == 8'h03, "R5 writing one no effect", d, 3);
    bbit(STAT, 3'd1, 1'b0);
    brd(STAT, d); chk(d == 8'h01, "R5 zero bit write clears", d, 1);
    bbit(STAT, 3'd0, 1'b0);
    brd(STAT, d); chk(d == 8'h00, "R7 zero bit write after read", d, 0);

    // R11 set beats armed clear; R5 armed clear and byte-write clear
    bwr(TXD, 8'h5A); cap = '0;
    sbit(1'b0); sbit(1'b0);
    bwr(TXD, 8'h11);
    brd(STAT, d); chk(d == 8'h02, "R4 collision flag second", d, 2);
    bwr(TXD, 8'h22);
    brd(STAT, d); chk(d == 8'h02, "R11 set wins over armed clear", d, 2);
    brd(TXD, d);  chk(d == 8'h22, "R4 latest colliding value", d, 8'h22);
    for (int k = 0; k < 6; k++) sbit(1'b0);
    chk(cap == 8'h5A, "R4 transfer unaffected second", cap, 8'h5A);
    brd(STAT, d); chk(d == 8'h03, "R6 both flags", d, 3);
    brd(RXD, d);
    brd(STAT, d); chk(d == 8'h02, "R8 only completion cleared", d, 2);
    bwr(TXD, 8'h44);
    brd(STAT, d); chk(d == 8'h00, "R5 armed transmit write clears", d, 0);
    sbit(1'b1);
    bwr(TXD, 8'h45);
    chk(irq == 1'b1, "R4 collision irq third", irq, 1);
    bwr(STAT, 8'h01);
    brd(STAT, d); chk(d == 8'h00, "R5 zero byte write clears", d, 0);
    for (int k = 0; k < 7; k++) sbit(1'b1);
    brd(STAT, d); chk(d == 8'h01, "R6 slave completion third", d, 1);
    brd(RXD, d);  chk(d == 8'hFF, "R3 slave ones byte", d, 8'hFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule